// File: doc/BRIEF.md
# Write-Invalidate MSI Snooping Cache Controller

This block is the coherence controller for one private write-back cache that sits on a shared snooping bus with a number of peer caches. It keeps every line in one of three states: Invalid, Shared (a clean copy that other caches may also hold) or Modified (a dirty copy that no other cache holds). Core loads and stores that can be served locally finish without touching the bus. All other accesses request the bus, wait for the grant, and then broadcast a read miss, a write miss or an invalidate. A dirty victim is written back first, in the same bus tenure.

The controller also watches the transactions that other caches broadcast. A foreign read miss that hits a dirty line makes this cache flush the data and drop to Shared. A foreign write miss or invalidate makes it drop the line to Invalid, and a dirty line is flushed first. Every invalidate it observes is acknowledged. When this cache issues an invalidate itself, it keeps its grant until every peer has acknowledged. This prevents another write to the same line from slipping in between the upgrade and its completion.

The cache is direct-mapped and holds one data word per line. The line index is taken from the low address bits and the tag from the rest.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `core_ready` is 1, and `bus_req`, `bus_valid`, `core_done`, `flush_valid` and `snp_ack` are 0. Because every line is Invalid, the first access to any address misses.
- R2: A read of a line that is not present raises `bus_req`. In the cycle after the grant is seen, the block drives `bus_valid` for one cycle with the request's address and `bus_cmd` set to read miss. The bus command codes are 1 read miss, 2 write miss, 3 invalidate and 4 write-back. The fill word is returned on `core_rdata`, and the line becomes Shared.
- R3: A read that hits a Shared or Modified line, and a write that hits a Modified line, finish with `core_done` one cycle after the check cycle and with no bus transaction. A read returns the last value written to that address.
- R4: A write that hits a Shared line broadcasts an invalidate (code 3). `bus_req` stays high, and `core_done` does not rise, until every peer bit of `peer_ack` has been seen. `core_done` rises in the cycle after the last acknowledgement, and the line becomes Modified.
- R5: A write to a line that is not present broadcasts a write miss (code 2). It waits for the fill, merges the written word, and leaves the line Modified, so a later read or write of that line hits.
- R6: A miss that would replace a Modified line with a different tag first issues a write-back (code 4) carrying the victim's address and dirty data. The miss command follows in the very next cycle, in the same grant.
- R7: A snooped read miss (code 1) that hits a Modified line produces `flush_valid` one cycle later, carrying that address and the dirty word. The line becomes Shared: it still hits for reads, and a later local write needs an invalidate.
- R8: A snooped write miss (code 2) that hits a line moves it to Invalid. If the line was Modified, the dirty word is flushed one cycle later; if it was Shared, nothing is flushed. The next local read misses.
- R9: Every snooped invalidate (code 3) produces a one-cycle `snp_ack` one cycle later, whether or not the address is held. A held line becomes Invalid.
- R10: A snoop whose tag differs from the line's tag, or a snooped write-back (code 4), leaves the line state unchanged and produces no flush.
- R11: `bus_valid` is driven only in a cycle whose previous cycle saw `bus_gnt` high. `core_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ready | output | 1 | Controller idle and able to take a request |
| core_req | input | 1 | One-cycle request strobe from the core |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Request address |
| core_wdata | input | DATA_W | Store data |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load data (echoes store data on writes) |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Broadcast of a transaction this cycle |
| bus_cmd | output | 3 | Transaction code |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Fill word |
| peer_ack | input | N_PEERS | Invalidate acknowledgements, one bit per peer |
| snp_valid | input | 1 | Foreign transaction observed |
| snp_cmd | input | 3 | Foreign transaction code |
| snp_addr | input | ADDR_W | Foreign transaction address |
| snp_ack | output | 1 | Acknowledge of a snooped invalidate |
| flush_valid | output | 1 | Dirty data supplied in response to a snoop |
| flush_addr | output | ADDR_W | Address of flushed data |
| flush_data | output | DATA_W | Flushed dirty word |

## Verification
A wrong line state never shows as a state value at the ports. It shows in the transaction count of the next access to that line: a stale Shared line turns a required miss into a silent hit, and a stale Modified line turns an invalidate into a silent write or loses a write-back. The bench therefore follows each snoop with a core access to the same address and checks both the number of bus commands and the returned word, so an error appears within one access. Acknowledgement timing is checked to the exact cycle: completion must come exactly one cycle after the last peer acknowledgement, with the request held throughout.

// File: rtl/msi_snoop_pkg.sv
package msi_snoop_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_INV    = 3'd3,
    BC_WB     = 3'd4
  } bus_cmd_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_CHECK, FS_ARB, FS_ISSUE, FS_FILL, FS_ACK, FS_DONE
  } fsm_e;

  // A core access that needs no bus transaction.
  function automatic logic local_complete(input logic we, input line_st_e st);
    return (st == LS_M) || (!we && st == LS_S);
  endfunction

  // Line state after a foreign transaction hits this line.
  function automatic line_st_e snoop_next(input bus_cmd_e c, input line_st_e st);
    case (c)
      BC_RDMISS: return (st == LS_M) ? LS_S : st;
      BC_WRMISS: return LS_I;
      BC_INV:    return LS_I;
      default:   return st;
    endcase
  endfunction

  // Dirty data must be supplied for this foreign transaction.
  function automatic logic snoop_flush(input bus_cmd_e c, input line_st_e st);
    return (st == LS_M) && (c == BC_RDMISS || c == BC_WRMISS);
  endfunction

  // Command this cache broadcasts once it owns the bus.
  function automatic bus_cmd_e pick_cmd(input logic victim_dirty, input logic we,
                                        input logic present);
    if (victim_dirty) return BC_WB;
    if (we && present) return BC_INV;
    if (we) return BC_WRMISS;
    return BC_RDMISS;
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_snoop_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  // core-side port (read and write)
  input  logic [IDX_W-1:0]  a_idx,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_dat,
  input  logic              l_st_we,
  input  line_st_e          l_st,
  input  logic              l_tag_we,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic              l_dat_we,
  input  logic [DATA_W-1:0] l_dat,
  // snoop-side port (read, state write)
  input  logic [IDX_W-1:0]  b_idx,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_dat,
  input  logic              s_st_we,
  input  line_st_e          s_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  line_st_e          st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wire a_sel = (a_idx == IDX_W'(g));
    wire b_sel = (b_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= LS_I;
        dat_q[g] <= '0;
      end else begin
        if (l_tag_we && a_sel) tag_q[g] <= l_tag;
        if (l_dat_we && a_sel) dat_q[g] <= l_dat;
        if (s_st_we && b_sel)      st_q[g] <= s_st;
        else if (l_st_we && a_sel) st_q[g] <= l_st;
      end
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];
  assign b_dat = dat_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_dat,
  output logic              st_we,
  output line_st_e          st_new,
  output logic              snp_hit,
  output logic              snp_ack,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  bus_cmd_e cmd;
  logic     need_flush;

  assign cmd        = bus_cmd_e'(snp_cmd);
  assign snp_hit    = snp_valid && (line_st != LS_I) &&
                      (line_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign st_new     = snoop_next(cmd, line_st);
  assign st_we      = snp_hit && (st_new != line_st);
  assign need_flush = snp_hit && snoop_flush(cmd, line_st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_ack     <= 1'b0;
      flush_valid <= 1'b0;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      snp_ack     <= snp_valid && (cmd == BC_INV);
      flush_valid <= need_flush;
      if (need_flush) begin
        flush_addr <= snp_addr;
        flush_data <= line_dat;
      end
    end
  end

endmodule

// File: rtl/msi_ack_tracker.sv
module msi_ack_tracker #(
  parameter int N_PEERS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [N_PEERS-1:0] peer_ack,
  output logic               all_acked
);
  logic [N_PEERS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= '0;
    else if (!active) seen_q <= '0;
    else              seen_q <= seen_q | peer_ack;
  end

  assign all_acked = active && (&(seen_q | peer_ack));

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 8,
  parameter int N_PEERS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               core_ready,
  input  logic               core_req,
  input  logic               core_we,
  input  logic [ADDR_W-1:0]  core_addr,
  input  logic [DATA_W-1:0]  core_wdata,
  output logic               core_done,
  output logic [DATA_W-1:0]  core_rdata,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_valid,
  output logic [2:0]         bus_cmd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               fill_valid,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic [N_PEERS-1:0] peer_ack,
  input  logic               snp_valid,
  input  logic [2:0]         snp_cmd,
  input  logic [ADDR_W-1:0]  snp_addr,
  output logic               snp_ack,
  output logic               flush_valid,
  output logic [ADDR_W-1:0]  flush_addr,
  output logic [DATA_W-1:0]  flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e st_q, st_d;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q;

  wire [IDX_W-1:0] r_idx   = r_addr[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag   = r_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] snp_idx = snp_addr[IDX_W-1:0];

  // line store wiring
  logic [TAG_W-1:0]  l_tag_rd, s_tag_rd;
  line_st_e          l_st_rd, s_st_rd;
  logic [DATA_W-1:0] l_dat_rd, s_dat_rd;
  logic              l_st_we, l_tag_we, l_dat_we;
  line_st_e          l_st_wr;
  logic [DATA_W-1:0] l_dat_wr;
  logic              s_st_we;
  line_st_e          s_st_wr;

  // named internal events
  logic     tag_hit, local_ok, victim_dirty, snoop_clash;
  logic     ev_local_hit, waiting_acks, acks_complete, snp_hit;
  bus_cmd_e issue_cmd;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (r_idx),
    .a_tag    (l_tag_rd),
    .a_st     (l_st_rd),
    .a_dat    (l_dat_rd),
    .l_st_we  (l_st_we),
    .l_st     (l_st_wr),
    .l_tag_we (l_tag_we),
    .l_tag    (r_tag),
    .l_dat_we (l_dat_we),
    .l_dat    (l_dat_wr),
    .b_idx    (snp_idx),
    .b_tag    (s_tag_rd),
    .b_st     (s_st_rd),
    .b_dat    (s_dat_rd),
    .s_st_we  (s_st_we),
    .s_st     (s_st_wr)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_addr    (snp_addr),
    .line_tag    (s_tag_rd),
    .line_st     (s_st_rd),
    .line_dat    (s_dat_rd),
    .st_we       (s_st_we),
    .st_new      (s_st_wr),
    .snp_hit     (snp_hit),
    .snp_ack     (snp_ack),
    .flush_valid (flush_valid),
    .flush_addr  (flush_addr),
    .flush_data  (flush_data)
  );

  msi_ack_tracker #(.N_PEERS(N_PEERS)) u_acks (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (waiting_acks),
    .peer_ack  (peer_ack),
    .all_acked (acks_complete)
  );

  assign tag_hit      = (l_st_rd != LS_I) && (l_tag_rd == r_tag);
  assign local_ok     = tag_hit && local_complete(r_we, l_st_rd);
  assign victim_dirty = (l_st_rd == LS_M) && (l_tag_rd != r_tag);
  assign snoop_clash  = snp_valid && (snp_idx == r_idx);
  assign issue_cmd    = pick_cmd(victim_dirty, r_we, tag_hit);
  assign ev_local_hit = (st_q == FS_CHECK) && !snoop_clash && local_ok;
  assign waiting_acks = (st_q == FS_ACK);

  always_comb begin
    st_d     = st_q;
    l_st_we  = 1'b0;
    l_st_wr  = LS_I;
    l_tag_we = 1'b0;
    l_dat_we = 1'b0;
    l_dat_wr = r_wdata;
    unique case (st_q)
      FS_IDLE:  if (core_req) st_d = FS_CHECK;
      FS_CHECK: begin
        if (!snoop_clash) begin
          if (local_ok) begin
            if (r_we) begin
              l_dat_we = 1'b1;
              l_st_we  = 1'b1;
              l_st_wr  = LS_M;
            end
            st_d = FS_DONE;
          end else begin
            st_d = FS_ARB;
          end
        end
      end
      FS_ARB:   if (bus_gnt) st_d = FS_ISSUE;
      FS_ISSUE: begin
        if (issue_cmd == BC_WB) begin
          l_st_we = 1'b1;
          l_st_wr = LS_I;
        end else if (issue_cmd == BC_INV) begin
          st_d = FS_ACK;
        end else begin
          st_d = FS_FILL;
        end
      end
      FS_FILL: begin
        if (fill_valid) begin
          l_tag_we = 1'b1;
          l_st_we  = 1'b1;
          l_st_wr  = r_we ? LS_M : LS_S;
          l_dat_we = 1'b1;
          l_dat_wr = r_we ? r_wdata : fill_data;
          st_d     = FS_DONE;
        end
      end
      FS_ACK: begin
        if (acks_complete) begin
          l_dat_we = 1'b1;
          l_st_we  = 1'b1;
          l_st_wr  = LS_M;
          st_d     = FS_DONE;
        end
      end
      FS_DONE:  st_d = FS_IDLE;
      default:  st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == FS_IDLE && core_req) begin
        r_we    <= core_we;
        r_addr  <= core_addr;
        r_wdata <= core_wdata;
      end
      if (ev_local_hit)                     rdata_q <= r_we ? r_wdata : l_dat_rd;
      if (st_q == FS_FILL && fill_valid)    rdata_q <= r_we ? r_wdata : fill_data;
      if (st_q == FS_ACK && acks_complete)  rdata_q <= r_wdata;
    end
  end

  assign core_ready = (st_q == FS_IDLE);
  assign core_done  = (st_q == FS_DONE);
  assign core_rdata = rdata_q;
  assign bus_req    = (st_q == FS_ARB) || (st_q == FS_ISSUE) ||
                      (st_q == FS_FILL) || (st_q == FS_ACK);
  assign bus_valid  = (st_q == FS_ISSUE);
  assign bus_cmd    = bus_valid ? issue_cmd : BC_NONE;
  assign bus_addr   = victim_dirty ? {l_tag_rd, r_idx} : r_addr;
  assign bus_wdata  = victim_dirty ? l_dat_rd : '0;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
  import msi_snoop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       core_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_valid,
  input logic [2:0] bus_cmd,
  input logic       snp_valid,
  input logic [2:0] snp_cmd,
  input logic       snp_ack,
  input logic       flush_valid,
  input logic       ev_local_hit,
  input logic       waiting_acks,
  input logic       acks_complete
);

  assert_valid_after_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(bus_gnt));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  assert_hit_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local_hit |=> (core_done && !bus_req));

  assert_inv_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_INV) |=> waiting_acks);

  assert_inv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_acks && !acks_complete) |=> (bus_req && !core_done));

  assert_wb_then_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_WB) |=>
      (bus_valid && (bus_cmd == BC_RDMISS || bus_cmd == BC_WRMISS)));

  assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> ($past(snp_valid) &&
                     ($past(snp_cmd) == BC_RDMISS || $past(snp_cmd) == BC_WRMISS)));

  assert_ack_follows_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_INV) |=> snp_ack);

  assert_ack_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack |-> $past(snp_valid && snp_cmd == BC_INV));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_done     (core_done),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_valid     (bus_valid),
  .bus_cmd       (bus_cmd),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_ack       (snp_ack),
  .flush_valid   (flush_valid),
  .ev_local_hit  (ev_local_hit),
  .waiting_acks  (waiting_acks),
  .acks_complete (acks_complete)
);

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NP = 2;
  localparam logic [2:0] C_RD = 3'd1, C_WR = 3'd2, C_INV = 3'd3, C_WB = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic core_ready, core_req = 0, core_we = 0, core_done;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, core_rdata;
  logic bus_req, bus_gnt = 0, bus_valid;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic fill_valid = 0;
  logic [DW-1:0] fill_data = '0;
  logic [NP-1:0] peer_ack = '0;
  logic snp_valid = 0;
  logic [2:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_ack, flush_valid;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW), .N_PEERS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .core_req(core_req),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_done(core_done), .core_rdata(core_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fill_valid(fill_valid),
    .fill_data(fill_data), .peer_ack(peer_ack), .snp_valid(snp_valid),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_ack(snp_ack),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] ref_v [64];
  logic [2:0]    log_cmd [8];
  logic [AW-1:0] log_addr [8];
  logic [DW-1:0] log_data [8];
  int n_log = 0, ack_t = 0, last_ack_cyc = 0, done_cyc = 0;
  bit fill_pend = 0, inv_wait = 0, req_dropped = 0;
  logic [AW-1:0] fill_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus agent: grant, memory fill, peer acknowledgements, memory updates
  always @(negedge clk) begin
    bus_gnt    <= bus_req;
    fill_valid <= 1'b0;
    peer_ack   <= '0;
    if (fill_pend) begin
      fill_valid <= 1'b1;
      fill_data  <= mem[fill_addr];
      fill_pend  = 0;
    end
    if (ack_t > 0) begin
      ack_t++;
      if (ack_t == 3) peer_ack <= 2'b01;
      if (ack_t == 5) begin peer_ack <= 2'b10; last_ack_cyc = cyc; ack_t = 0; end
    end
    if (inv_wait && !core_done && !bus_req) req_dropped = 1;
    if (core_done) inv_wait = 0;
    if (bus_valid) begin
      chk(bus_gnt, "R11", "bus_valid without grant", 0, 1);
      if (n_log < 8) begin
        log_cmd[n_log] = bus_cmd; log_addr[n_log] = bus_addr; log_data[n_log] = bus_wdata;
      end
      n_log++;
      if (bus_cmd == C_RD || bus_cmd == C_WR) begin fill_pend = 1; fill_addr <= bus_addr; end
      if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
      if (bus_cmd == C_INV) begin ack_t = 1; inv_wait = 1; end
    end
    if (flush_valid) mem[flush_addr] = flush_data;
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int guard = 0;
    while (!core_ready) @(negedge clk);
    n_log = 0; req_dropped = 0;
    core_req = 1; core_we = we; core_addr = a; core_wdata = d;
    @(negedge clk);
    core_req = 0;
    while (!core_done && guard < 300) begin @(negedge clk); guard++; end
    done_cyc = cyc;
    @(negedge clk);
    chk(!core_done, "R11", "core_done width", 1, 0);
  endtask

  task automatic snoop(input logic [2:0] c, input logic [AW-1:0] a,
                       output bit fv, output bit ak, output logic [AW-1:0] fa,
                       output logic [DW-1:0] fd);
    while (!core_ready) @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    fv = flush_valid; ak = snp_ack; fa = flush_addr; fd = flush_data;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return AW'((t << 2) | i);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    bit fv, ak;
    logic [AW-1:0] fa;
    logic [DW-1:0] fd;
    for (int k = 0; k < 64; k++) begin mem[k] = DW'(k * 7 + 3); ref_v[k] = mem[k]; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(core_ready && !bus_req && !bus_valid && !core_done && !flush_valid && !snp_ack,
        "R1", "reset outputs", {core_ready, bus_req, bus_valid, core_done, flush_valid, snp_ack},
        32);

    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a, a2;
      logic [DW-1:0] v;
      a = mk(1, i); a2 = mk(2, i);
      // R1/R2: cold read misses once, line then Shared
      do_op(0, a, 0);
      chk(n_log == 1 && log_cmd[0] == C_RD && log_addr[0] == a, "R2", "read miss cmd",
          n_log * 16 + int'(log_cmd[0]), 16 + 1);
      chk(core_rdata == ref_v[a], "R1", "cold read data", core_rdata, ref_v[a]);
      do_op(0, a, 0);
      chk(n_log == 0 && core_rdata == ref_v[a], "R3", "read hit on S", n_log, 0);
      // R4: upgrade with invalidate, waits for acks
      v = DW'(8'hA0 + i);
      do_op(1, a, v); ref_v[a] = v;
      chk(n_log == 1 && log_cmd[0] == C_INV && log_addr[0] == a, "R4", "invalidate cmd",
          int'(log_cmd[0]), 3);
      chk(done_cyc == last_ack_cyc + 1, "R4", "done after last ack", done_cyc,
          last_ack_cyc + 1);
      chk(!req_dropped, "R4", "bus_req held during acks", 1, 0);
      do_op(0, a, 0);
      chk(n_log == 0 && core_rdata == v, "R3", "read hit on M", core_rdata, v);
      v = DW'(8'hB0 + i);
      do_op(1, a, v); ref_v[a] = v;
      chk(n_log == 0, "R3", "write hit on M", n_log, 0);
      // R6/R5: evict dirty, then write miss
      v = DW'(8'hC0 + i);
      do_op(1, a2, v); ref_v[a2] = v;
      chk(n_log == 2 && log_cmd[0] == C_WB && log_addr[0] == a && log_data[0] == ref_v[a],
          "R6", "write-back of victim", int'(log_data[0]), ref_v[a]);
      chk(log_cmd[1] == C_WR && log_addr[1] == a2, "R5", "write miss cmd",
          int'(log_cmd[1]), 2);
      do_op(0, a2, 0);
      chk(n_log == 0 && core_rdata == v, "R5", "write miss leaves M", core_rdata, v);
      do_op(0, a, 0);
      chk(n_log == 2 && log_cmd[0] == C_WB && log_data[0] == v && log_cmd[1] == C_RD,
          "R6", "evict then read miss", n_log, 2);
      chk(core_rdata == ref_v[a], "R6", "refill after write-back", core_rdata, ref_v[a]);
      // R9/R10: foreign invalidate to other tag, write-back snoop
      snoop(C_INV, a2, fv, ak, fa, fd);
      chk(ak && !fv, "R9", "ack for unheld invalidate", ak, 1);
      snoop(C_WB, a, fv, ak, fa, fd);
      chk(!ak && !fv, "R10", "write-back snoop ignored", fv, 0);
      do_op(0, a, 0);
      chk(n_log == 0, "R10", "line still present", n_log, 0);
      // R7: snooped read miss on M flushes, line to S
      v = DW'(8'hD0 + i);
      do_op(1, a, v); ref_v[a] = v;
      snoop(C_RD, a, fv, ak, fa, fd);
      chk(fv && fa == a && fd == v, "R7", "flush data", fd, v);
      do_op(0, a, 0);
      chk(n_log == 0 && core_rdata == v, "R7", "read hit after downgrade", n_log, 0);
      v = DW'(8'hE0 + i);
      do_op(1, a, v); ref_v[a] = v;
      chk(n_log == 1 && log_cmd[0] == C_INV, "R7", "write needs invalidate",
          int'(log_cmd[0]), 3);
      // R8: snooped write miss on M flushes then invalidates
      snoop(C_WR, a, fv, ak, fa, fd);
      chk(fv && fd == v, "R8", "flush on write miss of M", fd, v);
      mem[a] = DW'(8'h50 + i); ref_v[a] = mem[a];
      do_op(0, a, 0);
      chk(n_log == 1 && log_cmd[0] == C_RD && core_rdata == ref_v[a], "R8",
          "read misses after M invalidated", core_rdata, ref_v[a]);
      snoop(C_WR, a, fv, ak, fa, fd);
      chk(!fv, "R8", "no flush for S", fv, 0);
      mem[a] = DW'(8'h60 + i); ref_v[a] = mem[a];
      do_op(0, a, 0);
      chk(n_log == 1 && core_rdata == ref_v[a], "R8", "read misses after S invalidated",
          core_rdata, ref_v[a]);
      // R9: held Shared line invalidated and acked
      snoop(C_INV, a, fv, ak, fa, fd);
      chk(ak && !fv, "R9", "ack for held invalidate", ak, 1);
      do_op(0, a, 0);
      chk(n_log == 1 && log_cmd[0] == C_RD, "R9", "read misses after invalidate", n_log, 1);
    end
    summary();
  end

endmodule